// File: doc/BRIEF.md
# Quadrature Knob Direction Sampler

This block takes the two phase lines of a mechanical rotary knob and keeps a free-running 16-bit position count. Both phases are brought into the clock domain through two flops and then debounced. Only legal single-phase Gray steps move the count up or down. A prescaler produces a sampling tick at a fixed wall-clock period, 100 ms by default.

On every tick the live count is compared with the value captured on the previous tick, and the block reports one movement verdict for that period. The verdict is forward, backward or nothing. A band of MAX_STEP counts at the top and bottom of the 16-bit range lets the block classify a move that crosses zero by its true direction rather than by raw magnitude. MAX_STEP is the largest movement expected in one period.

The verdict appears as a one-cycle strobe with a two-bit direction code. The live count is also visible at all times.

Top module: `qdec_dir_sampler`

## Requirements
- R1: While reset is held low at a clock edge, the count, the strobe and the direction code are all zero after that edge.
- R2: Each phase passes through two synchronising flops. A new level is accepted only after it has been seen for DEB_CYC consecutive synchronised cycles; a pulse shorter than that leaves the count unchanged.
- R3: With phases written as {A,B}, the forward order is 00→10→11→01→00. One accepted step along that order adds one to the count, and one step against it subtracts one. The count wraps modulo 2^16 in both directions.
- R4: If both accepted phase levels change in the same cycle, the count does not change.
- R5: The sampling tick recurs every CLK_HZ/1000*PERIOD_MS cycles. Any event strobe comes in the cycle after a tick and lasts one cycle. The direction code is 2'b01 for forward and 2'b10 for backward, and it is 2'b00 whenever the strobe is low.
- R6: A tick that finds the count equal to the captured value produces no strobe.
- R7: If the captured value lies outside both end windows, a larger count is reported as forward and a smaller count as backward.
- R8: Suppose the captured value is at least 0xFFFF−MAX_STEP and the count differs from it. The verdict is forward when the count is at most MAX_STEP or above the captured value; otherwise it is backward.
- R9: Suppose the captured value is at most MAX_STEP and the count differs from it. The verdict is backward when the count is at least 0xFFFF−MAX_STEP or below the captured value; otherwise it is forward.
- R10: Every tick captures the current count, whether or not a strobe follows.
- R11: The first tick after reset only captures the count and never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ph_a_i | input | 1 | Knob phase A, asynchronous |
| ph_b_i | input | 1 | Knob phase B, asynchronous |
| step_evt_o | output | 1 | One-cycle movement verdict strobe |
| step_dir_o | output | 2 | Direction code: 01 forward, 10 backward, 00 idle |
| pos_o | output | CNT_W | Live position count |

## Verification
A position step can be accepted on the same clock edge as a sampling tick. In that case the captured value must be the count from before that edge, and the new step belongs to the next period. The bench keeps sweeping the knob through whole sampling periods, so accepted steps regularly fall on tick cycles. These collisions are judged by a behavioural model that recomputes the count, the captured value and the verdict on every clock. The other collision occurs when one period spans the wrap point: the count moves across zero while the captured value sits inside an end window. The bench provokes this by stepping backward from zero and then forward again across zero.

// File: rtl/qdec_pkg.sv
// Shared types for the quadrature direction sampler.
package qdec_pkg;

    // Movement verdict codes as they appear on the direction port.
    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_FWD  = 2'b01,
        DIR_BWD  = 2'b10
    } qdec_dir_e;

    // Single-step decode result of the phase pair.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } qdec_step_e;

endpackage

// File: rtl/qdec_in_cond.sv
// Input conditioning for NPH asynchronous phase lines.
// Each line passes through a two-flop synchroniser and then a level filter.
// The filter takes a new level only after it has held for DEB_CYC consecutive
// cycles. Assumes DEB_CYC >= 1 and reset values of zero for every line.
module qdec_in_cond #(
    parameter int NPH     = 2,
    parameter int DEB_CYC = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] raw_i,
    output logic [NPH-1:0] clean_o
);

    localparam int DW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC + 1);
    localparam logic [DW-1:0] RUN_LAST = DW'(DEB_CYC - 1);

    for (genvar g = 0; g < NPH; g++) begin : g_line
        logic          meta_q;
        logic          sync_q;
        logic          level_q;
        logic [DW-1:0] run_q;

        // Bring the raw line into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= raw_i[g];
                sync_q <= meta_q;
            end
        end

        // Accept a new level once it has persisted long enough.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_q <= 1'b0;
                run_q   <= '0;
            end else if (sync_q == level_q) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                level_q <= sync_q;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end

        assign clean_o[g] = level_q;
    end

endmodule

// File: rtl/qdec_pos_counter.sv
// Gray-step decoder and wrapping position counter.
// The forward order of {A,B} is 00 -> 10 -> 11 -> 01 -> 00. A legal step
// moves the count by one. No change, or both lines changing at once,
// leaves it alone. Assumes the phase inputs are already clean and synchronous.
module qdec_pos_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ph_a_i,
    input  logic             ph_b_i,
    output logic [CNT_W-1:0] pos_o
);

    logic [1:0]       prev_q;
    logic [1:0]       cur;
    qdec_step_e       step;
    logic [CNT_W-1:0] pos_q;

    assign cur = {ph_a_i, ph_b_i};

    // Classify the transition from the previous pair to the current pair.
    always_comb begin
        unique case ({prev_q, cur})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step = STEP_UP;
            4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: step = STEP_DOWN;
            default:                                step = STEP_HOLD;
        endcase
    end

    // Remember the pair and move the count on a legal step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 2'b00;
            pos_q  <= '0;
        end else begin
            prev_q <= cur;
            if (step == STEP_UP) begin
                pos_q <= pos_q + 1'b1;
            end else if (step == STEP_DOWN) begin
                pos_q <= pos_q - 1'b1;
            end
        end
    end

    assign pos_o = pos_q;

endmodule

// File: rtl/qdec_tick_gen.sv
// Sampling period prescaler. It raises a registered one-cycle tick every
// TICK_DIV cycles, with the first tick TICK_DIV cycles after reset.
// Assumes TICK_DIV >= 2.
module qdec_tick_gen #(
    parameter int TICK_DIV = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int TW = $clog2(TICK_DIV);
    localparam logic [TW-1:0] TC_LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] tc_q;
    logic          tick_q;

    // Count through one period and pulse at its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q   <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= (tc_q == TC_LAST);
            tc_q   <= (tc_q == TC_LAST) ? '0 : tc_q + 1'b1;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/qdec_dir_judge.sv
// Snapshot and direction verdict. On each tick it compares the live count
// with the previous snapshot, taking account of the wrap windows at both
// ends of the range. It then registers a one-cycle verdict and captures the
// new snapshot. The first tick after reset only captures.
// Assumes MAX_STEP < 2^(CNT_W-1), so the windows do not overlap.
module qdec_dir_judge
    import qdec_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MAX_STEP = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] pos_i,
    output logic             evt_o,
    output logic [1:0]       dir_o
);

    localparam logic [CNT_W-1:0] TOP_V  = '1;
    localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(MAX_STEP);
    localparam logic [CNT_W-1:0] HI_LIM = TOP_V - LO_LIM;

    logic [CNT_W-1:0] snap_q;
    logic             armed_q;
    logic             evt_q;
    qdec_dir_e        dir_q;
    qdec_dir_e        verdict;

    // Decide the direction of the live count relative to the snapshot.
    always_comb begin
        if (pos_i == snap_q) begin
            verdict = DIR_NONE;
        end else if (snap_q >= HI_LIM) begin
            verdict = (pos_i <= LO_LIM || pos_i > snap_q) ? DIR_FWD : DIR_BWD;
        end else if (snap_q <= LO_LIM) begin
            verdict = (pos_i >= HI_LIM || pos_i < snap_q) ? DIR_BWD : DIR_FWD;
        end else begin
            verdict = (pos_i < snap_q) ? DIR_BWD : DIR_FWD;
        end
    end

    // Capture the snapshot on every tick and register the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= '0;
            armed_q <= 1'b0;
            evt_q   <= 1'b0;
            dir_q   <= DIR_NONE;
        end else if (tick_i) begin
            snap_q  <= pos_i;
            armed_q <= 1'b1;
            evt_q   <= armed_q && (verdict != DIR_NONE);
            dir_q   <= armed_q ? verdict : DIR_NONE;
        end else begin
            evt_q <= 1'b0;
            dir_q <= DIR_NONE;
        end
    end

    assign evt_o = evt_q;
    assign dir_o = dir_q;

endmodule

// File: rtl/qdec_dir_sampler.sv
// Top of the quadrature direction sampler. It conditions the two phase
// lines, keeps the wrapping position count, divides the clock down to the
// sampling period and issues one direction verdict per period.
// Assumes CLK_HZ/1000*PERIOD_MS >= 2.
module qdec_dir_sampler #(
    parameter int CNT_W     = 16,
    parameter int MAX_STEP  = 100,
    parameter int CLK_HZ    = 50_000_000,
    parameter int PERIOD_MS = 100,
    parameter int DEB_CYC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ph_a_i,
    input  logic             ph_b_i,
    output logic             step_evt_o,
    output logic [1:0]       step_dir_o,
    output logic [CNT_W-1:0] pos_o
);

    localparam int TICK_DIV = (CLK_HZ / 1000) * PERIOD_MS;

    logic [1:0]       clean_w;
    logic             tick_w;
    logic [CNT_W-1:0] pos_w;

    qdec_in_cond #(.NPH(2), .DEB_CYC(DEB_CYC)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({ph_a_i, ph_b_i}),
        .clean_o (clean_w)
    );

    qdec_pos_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_a_i (clean_w[1]),
        .ph_b_i (clean_w[0]),
        .pos_o  (pos_w)
    );

    qdec_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    qdec_dir_judge #(.CNT_W(CNT_W), .MAX_STEP(MAX_STEP)) u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_w),
        .pos_i  (pos_w),
        .evt_o  (step_evt_o),
        .dir_o  (step_dir_o)
    );

    assign pos_o = pos_w;

endmodule

// File: rtl/qdec_dir_sampler_chk.sv
// Property checker for the direction sampler, bound to every instance of
// the top. It watches the ports and the internal sampling tick.
module qdec_dir_sampler_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             evt,
    input logic [1:0]       dir,
    input logic [CNT_W-1:0] pos
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic ticked_q;

    // Remember whether a tick has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ticked_q <= 1'b0;
        else if (tick) ticked_q <= 1'b1;
    end

    // R5
    dir_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (dir == 2'b01 || dir == 2'b10));

    // R5
    idle_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |-> (dir == 2'b00));

    // R5
    evt_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(tick));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != $past(pos)) |-> (pos == $past(pos) + ONE || pos == $past(pos) - ONE));

    // R11
    first_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ticked_q) |=> !evt);

endmodule

bind qdec_dir_sampler qdec_dir_sampler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_w),
    .evt   (step_evt_o),
    .dir   (step_dir_o),
    .pos   (pos_o)
);

// File: tb/qdec_dir_sampler_tb_top.sv
// Bench for the direction sampler. A behavioural model is compared against
// the design on every clock, and directed checks cover the boundary cases.
module qdec_dir_sampler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int MAX_STEP   = 100;
    localparam int CLK_HZ     = 4000;
    localparam int PERIOD_MS  = 10;
    localparam int DEB_CYC    = 3;
    localparam int TICK_DIV   = (CLK_HZ / 1000) * PERIOD_MS;
    localparam int HOLD       = 6;
    localparam int MODV       = 1 << CNT_W;
    localparam int TOPV       = MODV - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pa = 1'b0;
    logic             pb = 1'b0;
    logic             evt;
    logic [1:0]       dir;
    logic [CNT_W-1:0] pos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    qdec_dir_sampler #(
        .CNT_W(CNT_W), .MAX_STEP(MAX_STEP), .CLK_HZ(CLK_HZ),
        .PERIOD_MS(PERIOD_MS), .DEB_CYC(DEB_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ph_a_i(pa), .ph_b_i(pb),
        .step_evt_o(evt), .step_dir_o(dir), .pos_o(pos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit    pipe_a[$];
    bit    pipe_b[$];
    int    run_a, run_b;
    bit    f_a, f_b;
    int    m_prev_idx, m_pos, m_snap, m_tc;
    bit    m_tick, m_seen, m_evt;
    int    m_dir;
    string m_rule;
    int    hit_r6, hit_r7, hit_r8, hit_r9;

    function automatic int pair_idx(bit a, bit b);
        case ({a, b})
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic void judge(input int now, input int old,
                                  output int d, output string rule);
        if (now == old) begin
            d = 0; rule = "R6";
        end else if (old >= TOPV - MAX_STEP) begin
            rule = "R8";
            d = (now <= MAX_STEP || now > old) ? 1 : 2;
        end else if (old <= MAX_STEP) begin
            rule = "R9";
            d = (now >= TOPV - MAX_STEP || now < old) ? 2 : 1;
        end else begin
            rule = "R7";
            d = (now < old) ? 2 : 1;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pipe_a = '{0, 0}; pipe_b = '{0, 0};
            run_a = 0; run_b = 0; f_a = 0; f_b = 0;
            m_prev_idx = 0; m_pos = 0; m_snap = 0; m_tc = 0;
            m_tick = 0; m_seen = 0; m_evt = 0; m_dir = 0; m_rule = "R1";
        end else begin
            int d; string r; int ci; int delta;
            // verdict stage uses the count from before this edge (R10 capture)
            m_evt = 0; m_dir = 0;
            if (m_tick) begin
                if (m_seen) begin
                    judge(m_pos, m_snap, d, r);
                    m_rule = r;
                    m_dir  = d;
                    m_evt  = (d != 0);
                    if (r == "R6") hit_r6++;
                    if (r == "R7" && d != 0) hit_r7++;
                    if (r == "R8" && d != 0) hit_r8++;
                    if (r == "R9" && d != 0) hit_r9++;
                end else begin
                    m_rule = "R11";
                end
                m_seen = 1;
                m_snap = m_pos;
            end
            // count stage
            ci = pair_idx(f_a, f_b);
            delta = (ci - m_prev_idx + 4) % 4;
            if (delta == 1) m_pos = (m_pos + 1) % MODV;
            else if (delta == 3) m_pos = (m_pos + MODV - 1) % MODV;
            m_prev_idx = ci;
            // filter stage
            if (pipe_a[0] == f_a) run_a = 0;
            else if (run_a == DEB_CYC - 1) begin f_a = pipe_a[0]; run_a = 0; end
            else run_a++;
            if (pipe_b[0] == f_b) run_b = 0;
            else if (run_b == DEB_CYC - 1) begin f_b = pipe_b[0]; run_b = 0; end
            else run_b++;
            // synchroniser stage
            void'(pipe_a.pop_front()); pipe_a.push_back(pa);
            void'(pipe_b.pop_front()); pipe_b.push_back(pb);
            // period stage
            m_tick = (m_tc == TICK_DIV - 1);
            m_tc   = (m_tc == TICK_DIV - 1) ? 0 : m_tc + 1;
        end
    end

    // ---------------- per-clock comparison ----------------
    int evt_pulses = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (evt) evt_pulses++;
            checks++;
            if (pos !== CNT_W'(m_pos)) begin
                errors++;
                $display("FAIL R3 count: actual %0d expected %0d", pos, m_pos);
            end
            checks++;
            if (evt !== m_evt || dir !== 2'(m_dir)) begin
                errors++;
                $display("FAIL %s/R5 verdict: actual evt=%0b dir=%b expected evt=%0b dir=%b",
                         m_rule, evt, dir, m_evt, 2'(m_dir));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int idx = 0;
    int exp_pos = 0;

    task automatic drive_idx(int i);
        case (i)
            0: {pa, pb} = 2'b00;
            1: {pa, pb} = 2'b10;
            2: {pa, pb} = 2'b11;
            default: {pa, pb} = 2'b01;
        endcase
    endtask

    task automatic step(bit fwd);
        idx = (idx + (fwd ? 1 : 3)) % 4;
        exp_pos = (exp_pos + (fwd ? 1 : MODV - 1)) % MODV;
        drive_idx(idx);
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic steps(bit fwd, int n);
        for (int k = 0; k < n; k++) step(fwd);
    endtask

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R1: outputs cleared by reset
        check(pos == 0, "R1 count", pos, 0);
        check(evt == 0 && dir == 0, "R1 strobe", {evt, dir}, 0);
        rst_n = 1'b1;

        // R11: move during the first period; its tick must stay quiet
        steps(1'b1, 2);
        repeat (TICK_DIV + 6 - 2 * HOLD) @(negedge clk);
        check(evt_pulses == 0, "R11 first tick quiet", evt_pulses, 0);

        // R2: a short glitch on A must not count
        pa = ~pa; repeat (2) @(negedge clk); pa = ~pa;
        repeat (10) @(negedge clk);
        check(pos == CNT_W'(exp_pos), "R2 glitch ignored", pos, exp_pos);

        // R4: both phases flip together (11 -> 00)
        {pa, pb} = 2'b00; idx = 0;
        repeat (HOLD + 6) @(negedge clk);
        check(pos == CNT_W'(exp_pos), "R4 double change ignored", pos, exp_pos);

        // R9 and R3: back across zero
        steps(1'b0, 10);
        repeat (8) @(negedge clk);
        check(pos == CNT_W'(exp_pos), "R3 wrap down", pos, exp_pos);

        // R6: idle periods
        repeat (2 * TICK_DIV + 4) @(negedge clk);

        // R8 and R3: forward across zero
        steps(1'b1, 20);
        repeat (8) @(negedge clk);
        check(pos == CNT_W'(exp_pos), "R3 wrap up", pos, exp_pos);

        // R7: well inside the range, both directions
        steps(1'b1, 150);
        steps(1'b0, 30);
        repeat (2 * TICK_DIV + 4) @(negedge clk);
        check(pos == CNT_W'(exp_pos), "R3 final count", pos, exp_pos);

        check(hit_r6 > 0, "R6 equal count seen", hit_r6, 1);
        check(hit_r7 > 0, "R7 mid-range verdict seen", hit_r7, 1);
        check(hit_r8 > 0, "R8 high window verdict seen", hit_r8, 1);
        check(hit_r9 > 0, "R9 low window verdict seen", hit_r9, 1);
        check(evt_pulses >= hit_r7 + hit_r8 + hit_r9, "R5 strobe count", evt_pulses,
              hit_r7 + hit_r8 + hit_r9);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule